// File: doc/BRIEF.md
# Debug Halt Control and Status Register

This block is the halt control and status word of a processor debug unit. A debugger writes it through a simple bus slave port to turn debug on, to request a halt, and to mask the maskable interrupts while the core is halted. The core drives the block's status inputs: its halted and sleeping levels, a lockup indication, instruction retirement, core resets, and the completion of a core-register transfer. The debugger reads that status back from the upper half of the same word.

A write takes effect only when the upper sixteen bits carry the unlock key 0xA05F. Any other value drops the whole write. Once the interrupt mask is set, it stays set while the core is released. It can change only during a write that keeps the core halted, and only if the core was already halted before that write. Two status bits are sticky: retirement-seen and reset-seen. Any read clears them, but an event that arrives in the same cycle as the read wins. The transfer-ready flag goes low when a transfer is selected and high again when that transfer completes.

Top module: `dbg_halt_ctl`

## Requirements
- R1: A write (wr_en high) updates the control bits only when wdata[31:16] equals 0xA05F; with any other key the whole write is ignored and the control outputs keep their values.
- R2: Debug enable is wdata bit 0 and halt request is wdata bit 1. Both reset to 0. While debug enable is 0, halt request and interrupt mask are held at 0.
- R3: The interrupt mask is wdata bit 3. An accepted write changes it only if halt request was already 1 before the write and the write's bit 1 is 1. Otherwise the mask keeps its previous value.
- R4: A read strobe (rd_en) loads rdata on the next clock edge with the current register value, and rdata holds between reads. The layout is: bit 0 enable, bit 1 halt, bit 3 mask, bit 16 ready, bit 17 halted, bit 18 sleeping, bit 19 lockup, bit 24 retired, bit 25 reset-seen. All other bits read 0. After reset, the first read returns 0x0201_0000.
- R5: The ready flag (bit 16) resets to 1, goes to 0 on sel_wr, and goes to 1 on xfer_done. When sel_wr and xfer_done arrive together, the flag goes to 0.
- R6: The halted bit (17) and the sleeping bit (18) copy core_halted and core_sleeping with a one-cycle register delay. Both reset to 0.
- R7: The lockup bit (19) is set by core_lockup. It is cleared in the cycle the core enters debug state, meaning core_halted is high while the halted bit is still 0. Entry takes priority over a lockup in the same cycle.
- R8: The retired bit (24) is set by core_retire while core_halted is low, and any read clears it. A set event in the same cycle as a read leaves the bit at 1.
- R9: The reset-seen bit (25) resets to 1 and is set by core_reset. Any read clears it, and a core_reset in the same cycle as a read leaves the bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wdata | input | 32 | Write data, key in [31:16] |
| rd_en | input | 1 | Single-cycle read strobe |
| rdata | output | 32 | Registered read data, valid the cycle after rd_en |
| sel_wr | input | 1 | Pulse: transfer-select register written |
| xfer_done | input | 1 | Pulse: core-register transfer complete |
| core_halted | input | 1 | Level: core is in debug state |
| core_sleeping | input | 1 | Level: core is sleeping |
| core_lockup | input | 1 | Core locked up after an unrecoverable exception |
| core_retire | input | 1 | Pulse: an instruction retired |
| core_reset | input | 1 | Pulse: core reset occurred |
| dbg_en | output | 1 | Debug enable control |
| halt_req | output | 1 | Halt request control |
| mask_ints | output | 1 | Mask maskable interrupts control |

## Verification
A clearing read and a sticky set event can land in the same cycle. The same applies to the transfer select and the transfer completion, and to debug-state entry and a lockup. The bench forces each of these collisions directly: it raises rd_en together with core_retire or core_reset, and sel_wr together with xfer_done. It then issues a second read and checks that the sticky bit survived, or that the clear won. Random cycles drive all strobes at once at moderate rates, so these overlaps also recur without direction. A reference model in the bench, written from the requirements, judges every bit each cycle.

// File: rtl/dhc_pkg.sv
package dhc_pkg;
    localparam int DW       = 32;
    localparam int KEY_W    = 16;
    localparam int B_EN     = 0;
    localparam int B_HALT   = 1;
    localparam int B_MASK   = 3;
    localparam int B_READY  = 16;
    localparam int B_HALTED = 17;
    localparam int B_SLEEP  = 18;
    localparam int B_LOCK   = 19;
    localparam int B_RETIRE = 24;
    localparam int B_RSTSEEN = 25;

    typedef struct packed {
        logic en;
        logic halt;
        logic mask;
    } ctrl_t;

    typedef struct packed {
        logic ready;
        logic halted;
        logic sleeping;
        logic lockup;
        logic retired;
        logic rst_seen;
    } stat_t;
endpackage

// File: rtl/dhc_ctrl.sv
module dhc_ctrl
    import dhc_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 16'hA05F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wkey,
    input  logic             w_en,
    input  logic             w_halt,
    input  logic             w_mask,
    output ctrl_t            ctrl
);
    ctrl_t ctrl_d, ctrl_q;
    logic  key_ok;

    always_comb begin
        ctrl_d = ctrl_q;
        key_ok = (wkey == KEY);
        if (wr_en && key_ok) begin
            ctrl_d.en   = w_en;
            ctrl_d.halt = w_halt;
            if (ctrl_q.halt && w_halt) begin
                ctrl_d.mask = w_mask;
            end
        end
        if (!ctrl_d.en) begin
            ctrl_d.halt = 1'b0;
            ctrl_d.mask = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    assert_bad_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wkey != KEY) |=> $stable(ctrl_q));

    assert_mask_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && ctrl_q.halt && w_halt)) |=>
            (ctrl_q.mask == $past(ctrl_q.mask)) || !ctrl_q.mask);

    assert_off_forces_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |-> (!ctrl_q.halt && !ctrl_q.mask));
endmodule

// File: rtl/dhc_status.sv
module dhc_status
    import dhc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_en,
    input  logic  sel_wr,
    input  logic  xfer_done,
    input  logic  core_halted,
    input  logic  core_sleeping,
    input  logic  core_lockup,
    input  logic  core_retire,
    input  logic  core_reset,
    output stat_t st
);
    stat_t st_d, st_q;
    logic  entering;

    always_comb begin
        st_d     = st_q;
        entering = core_halted && !st_q.halted;

        if (sel_wr)         st_d.ready = 1'b0;
        else if (xfer_done) st_d.ready = 1'b1;

        if (entering)         st_d.lockup = 1'b0;
        else if (core_lockup) st_d.lockup = 1'b1;

        if (core_retire && !core_halted) st_d.retired = 1'b1;
        else if (rd_en)                  st_d.retired = 1'b0;

        if (core_reset)  st_d.rst_seen = 1'b1;
        else if (rd_en)  st_d.rst_seen = 1'b0;

        st_d.halted   = core_halted;
        st_d.sleeping = core_sleeping;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ready    <= 1'b1;
            st_q.rst_seen <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    assert_ready_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> !st_q.ready);

    assert_ready_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !sel_wr) |=> st_q.ready);

    assert_lock_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halted && !st_q.halted) |=> !st_q.lockup);

    assert_retire_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_retire && !core_halted) |=> st_q.retired);

    assert_reset_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset |=> st_q.rst_seen);

    assert_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.halted == $past(core_halted)) && (st_q.sleeping == $past(core_sleeping)));
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
    import dhc_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 16'hA05F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    input  logic          sel_wr,
    input  logic          xfer_done,
    input  logic          core_halted,
    input  logic          core_sleeping,
    input  logic          core_lockup,
    input  logic          core_retire,
    input  logic          core_reset,
    output logic          dbg_en,
    output logic          halt_req,
    output logic          mask_ints
);
    ctrl_t ctrl;
    stat_t st;
    logic [DW-1:0] rdata_d, rdata_q;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[KEY_W-1:B_MASK+1], wdata[B_MASK-1:B_HALT+1]};

    dhc_ctrl #(.KEY(KEY)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wkey   (wdata[DW-1 -: KEY_W]),
        .w_en   (wdata[B_EN]),
        .w_halt (wdata[B_HALT]),
        .w_mask (wdata[B_MASK]),
        .ctrl   (ctrl)
    );

    dhc_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_en         (rd_en),
        .sel_wr        (sel_wr),
        .xfer_done     (xfer_done),
        .core_halted   (core_halted),
        .core_sleeping (core_sleeping),
        .core_lockup   (core_lockup),
        .core_retire   (core_retire),
        .core_reset    (core_reset),
        .st            (st)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            rdata_d            = '0;
            rdata_d[B_EN]      = ctrl.en;
            rdata_d[B_HALT]    = ctrl.halt;
            rdata_d[B_MASK]    = ctrl.mask;
            rdata_d[B_READY]   = st.ready;
            rdata_d[B_HALTED]  = st.halted;
            rdata_d[B_SLEEP]   = st.sleeping;
            rdata_d[B_LOCK]    = st.lockup;
            rdata_d[B_RETIRE]  = st.retired;
            rdata_d[B_RSTSEEN] = st.rst_seen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata     = rdata_q;
    assign dbg_en    = ctrl.en;
    assign halt_req  = ctrl.halt;
    assign mask_ints = ctrl.mask;

    assert_read_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rdata_q[B_RSTSEEN] == $past(st.rst_seen)) && (rdata_q[B_RETIRE] == $past(st.retired)));

    assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata_q));

    assert_key_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rdata_q[DW-1:B_RSTSEEN+1] == '0) && (rdata_q[B_RETIRE-1:B_LOCK+1] == '0));

    assert_halt_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> dbg_en);
endmodule

// File: tb/dbg_halt_ctl_tb_top.sv
module dbg_halt_ctl_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, wr_en, rd_en, sel_wr, xfer_done;
    logic core_halted, core_sleeping, core_lockup, core_retire, core_reset;
    logic [31:0] wdata, rdata;
    logic dbg_en, halt_req, mask_ints;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic m_en, m_halt, m_mask, m_rdy, m_hlt, m_slp, m_lck, m_ret, m_rst;
    logic [31:0] m_rdata;

    dbg_halt_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
        .rdata(rdata), .sel_wr(sel_wr), .xfer_done(xfer_done),
        .core_halted(core_halted), .core_sleeping(core_sleeping),
        .core_lockup(core_lockup), .core_retire(core_retire), .core_reset(core_reset),
        .dbg_en(dbg_en), .halt_req(halt_req), .mask_ints(mask_ints)
    );

    function automatic logic [31:0] compose_rd();
        logic [31:0] v;
        v = '0;
        v[0] = m_en; v[1] = m_halt; v[3] = m_mask;
        v[16] = m_rdy; v[17] = m_hlt; v[18] = m_slp; v[19] = m_lck;
        v[24] = m_ret; v[25] = m_rst;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_en = 0; m_halt = 0; m_mask = 0; m_rdy = 1; m_hlt = 0;
        m_slp = 0; m_lck = 0; m_ret = 0; m_rst = 1; m_rdata = '0;
    endtask

    task automatic model_step();
        logic nm;
        if (rd_en) m_rdata = compose_rd();
        if (wr_en && wdata[31:16] == 16'hA05F) begin
            nm = (m_halt && wdata[1]) ? wdata[3] : m_mask;
            m_en = wdata[0]; m_halt = wdata[1]; m_mask = nm;
        end
        if (!m_en) begin m_halt = 0; m_mask = 0; end
        if (sel_wr) m_rdy = 0; else if (xfer_done) m_rdy = 1;
        if (core_halted && !m_hlt) m_lck = 0; else if (core_lockup) m_lck = 1;
        if (core_retire && !core_halted) m_ret = 1; else if (rd_en) m_ret = 0;
        if (core_reset) m_rst = 1; else if (rd_en) m_rst = 0;
        m_hlt = core_halted;
        m_slp = core_sleeping;
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; sel_wr = 0; xfer_done = 0;
        core_lockup = 0; core_retire = 0; core_reset = 0; wdata = '0;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2 enable", {31'b0, dbg_en}, {31'b0, m_en});
        chk("R2 halt", {31'b0, halt_req}, {31'b0, m_halt});
        chk("R3 mask", {31'b0, mask_ints}, {31'b0, m_mask});
        chk("R4 layout", rdata & 32'hFCF0_FFF4, 32'h0);
        chk("R5 ready", {31'b0, rdata[16]}, {31'b0, m_rdata[16]});
        chk("R6 halted/sleep", {30'b0, rdata[18:17]}, {30'b0, m_rdata[18:17]});
        chk("R7 lockup", {31'b0, rdata[19]}, {31'b0, m_rdata[19]});
        chk("R8 retired", {31'b0, rdata[24]}, {31'b0, m_rdata[24]});
        chk("R9 reset seen", {31'b0, rdata[25]}, {31'b0, m_rdata[25]});
        chk("R4 control", rdata & 32'hB, m_rdata & 32'hB);
        idle();
    endtask

    task automatic do_read();
        rd_en = 1; cyc();
    endtask

    task automatic do_write(input logic [31:0] d);
        wr_en = 1; wdata = d; cyc();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        idle();
        core_halted = 0; core_sleeping = 0;
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        do_read();
        chk("R4 reset value", rdata, 32'h0201_0000);
        do_read();
        chk("R9 cleared by read", {31'b0, rdata[25]}, 32'h0);

        do_write(32'h1234_0003);
        chk("R1 wrong key ignored", {29'b0, mask_ints, halt_req, dbg_en}, 32'h0);
        do_write(32'hA05F_0001);
        chk("R1 right key accepted", {31'b0, dbg_en}, 32'h1);
        do_write(32'hA05F_000B);
        chk("R3 mask blocked, not yet halted", {30'b0, mask_ints, halt_req}, 32'h1);
        do_write(32'hA05E_0000);
        chk("R1 near key ignored", {31'b0, halt_req}, 32'h1);
        do_write(32'hA05F_000B);
        chk("R3 mask set while halted", {31'b0, mask_ints}, 32'h1);
        do_write(32'hA05F_0001);
        chk("R3 mask kept on release", {30'b0, mask_ints, halt_req}, 32'h2);
        do_write(32'hA05F_0000);
        chk("R2 disable clears mask", {31'b0, mask_ints}, 32'h0);

        core_retire = 1; rd_en = 1; cyc();
        do_read();
        chk("R8 set wins over read", {31'b0, rdata[24]}, 32'h1);
        core_reset = 1; rd_en = 1; cyc();
        do_read();
        chk("R9 set wins over read", {31'b0, rdata[25]}, 32'h1);

        sel_wr = 1; cyc();
        do_read();
        chk("R5 cleared by select", {31'b0, rdata[16]}, 32'h0);
        xfer_done = 1; cyc();
        do_read();
        chk("R5 set by done", {31'b0, rdata[16]}, 32'h1);
        sel_wr = 1; xfer_done = 1; cyc();
        do_read();
        chk("R5 select wins", {31'b0, rdata[16]}, 32'h0);

        core_lockup = 1; cyc();
        do_read();
        chk("R7 lockup set", {31'b0, rdata[19]}, 32'h1);
        core_halted = 1; core_lockup = 1; cyc();
        do_read();
        chk("R7 entry clears lockup", {29'b0, rdata[19:17]}, 32'h1);
        core_halted = 0;

        for (int i = 0; i < 4000; i++) begin
            wr_en = ($urandom % 4) == 0;
            wdata = $urandom;
            if (($urandom % 4) != 0) wdata[31:16] = 16'hA05F;
            rd_en = ($urandom % 3) == 0;
            sel_wr = ($urandom % 6) == 0;
            xfer_done = ($urandom % 6) == 0;
            if (($urandom % 10) == 0) core_halted = ~core_halted;
            if (($urandom % 10) == 0) core_sleeping = ~core_sleeping;
            core_lockup = ($urandom % 12) == 0;
            core_retire = ($urandom % 3) == 0;
            core_reset = ($urandom % 20) == 0;
            cyc();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule